// File: doc/BRIEF.md
# BCD Calendar Counter with Staged Update

This block keeps wall-clock time and date in packed BCD: seconds, minutes, hours, a weekday index, day of month, month and a two-digit year. A year value of 00 stands for 1970 and 99 for 2069. A single-cycle `tick` pulse, normally once per second, advances the calendar. Carries ripple from seconds up through the year in the cycle of the tick. The length of each month comes from the month number. February runs to 29 days only when the host has set the leap flag kept in the year register.

The host writes new time fields into a bank of staging registers. These writes leave the running counters alone. Writing the commit register with bit 15 set copies all seven staged fields, and the leap flag, into the counters in one step on the following clock edge. This means a partly written time is never seen running. Reads always return the live counters. A control bit selects 24-hour or 12-hour hour counting.

Top module: `cal_bcd_rtc`

## Requirements
- R1: After reset the live fields read seconds 0x00, minutes 0x00, hours 0x00, weekday 0, day 0x01, month 0x01, year 0x0000 (leap clear), and the control register reads 0x0001 (24-hour mode).
- R2: Writes to the field addresses (0 seconds, 1 minutes, 2 hours, 3 weekday, 4 day, 5 month, 6 year) change only the staging bank; reads of those addresses keep returning the live counters until a commit.
- R3: A write to address 7 with wdata bit 15 set loads every staged field into the counters on the next clock edge. Address 7 reads 0x8000 in the cycle between the write and the load, and 0x0000 afterwards. A write to address 7 with bit 15 clear does nothing.
- R4: On each tick the seconds advance in BCD (0x09 to 0x10). From 0x59 they wrap to 0x00 and advance the minutes, which wrap the same way from 0x59 and advance the hours.
- R5: In 24-hour mode (address 8 bit 0 = 1) the hours count 0x00 to 0x23; leaving 0x23 wraps them to 0x00 and advances the date.
- R6: In 12-hour mode (address 8 bit 0 = 0) hours bits 4:0 hold BCD 0x01 to 0x12 and bit 5 is the PM flag. 11 becomes 12 with the PM flag inverted, 12 becomes 01 with the flag kept, and 11 PM to 12 AM advances the date.
- R7: Each date advance increments the weekday, wrapping from 6 to 0.
- R8: A date advance past the last day of the month sets the day to 0x01 and increments the month. Months 0x04, 0x06, 0x09 and 0x11 end on day 0x30; the other months except February end on 0x31.
- R9: February (month 0x02) ends on day 0x28 when the leap flag (year register bit 15) is clear, and on 0x29 when it is set.
- R10: Leaving month 0x12 sets the month to 0x01 and increments the BCD year. Year 0x99 wraps to 0x00. The leap flag changes only by commit, never by counting.
- R11: A tick that arrives in the same cycle as the commit load is dropped; the counters take exactly the staged values.
- R12: Written fields are cut to their widths (seconds and minutes 7 bits, hours and day 6, weekday 3, month 5, year 8 plus leap bit 15); other bits read back as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle pulse that advances time by one second |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address for writes and reads |
| wdata | input | 16 | Register write data |
| rdata | output | 16 | Read data for `addr`, combinational from the live state |

## Verification
A wrong carry or month-length decision stays hidden until the chain crosses the boundary in question. The bench therefore loads times just before each rollover and reads every field after a known number of ticks. A bad field shows at the port on the first read after that tick. A wrong staging path shows as a field that changes before the commit, or that differs from the staged value one cycle after it. A random series of start times and tick counts, checked against a binary calendar model, catches slow drift such as a skipped day in one particular month.

// File: rtl/cal_pkg.sv
package cal_pkg;
    localparam int REG_W  = 16;
    localparam int ADDR_W = 4;
    localparam int SEC_W  = 7;
    localparam int MIN_W  = 7;
    localparam int HR_W   = 6;
    localparam int WD_W   = 3;
    localparam int MD_W   = 6;
    localparam int MON_W  = 5;
    localparam int YR_W   = 8;

    localparam logic [ADDR_W-1:0] ADR_SEC    = 4'd0;
    localparam logic [ADDR_W-1:0] ADR_MIN    = 4'd1;
    localparam logic [ADDR_W-1:0] ADR_HOUR   = 4'd2;
    localparam logic [ADDR_W-1:0] ADR_WDAY   = 4'd3;
    localparam logic [ADDR_W-1:0] ADR_MDAY   = 4'd4;
    localparam logic [ADDR_W-1:0] ADR_MON    = 4'd5;
    localparam logic [ADDR_W-1:0] ADR_YEAR   = 4'd6;
    localparam logic [ADDR_W-1:0] ADR_COMMIT = 4'd7;
    localparam logic [ADDR_W-1:0] ADR_CTRL   = 4'd8;

    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [MIN_W-1:0] min;
        logic [HR_W-1:0]  hour;
        logic [WD_W-1:0]  wday;
        logic [MD_W-1:0]  mday;
        logic [MON_W-1:0] mon;
        logic [YR_W-1:0]  year;
        logic             leap;
    } cal_time_t;

    localparam cal_time_t CAL_RESET = '{sec: 7'h00, min: 7'h00, hour: 6'h00,
                                        wday: 3'd0, mday: 6'h01, mon: 5'h01,
                                        year: 8'h00, leap: 1'b0};

    function automatic logic [7:0] bcd_inc8(input logic [7:0] v);
        if (v[3:0] >= 4'd9) bcd_inc8 = {v[7:4] + 4'd1, 4'd0};
        else                bcd_inc8 = {v[7:4], v[3:0] + 4'd1};
    endfunction
endpackage

// File: rtl/cal_shadow.sv
module cal_shadow
    import cal_pkg::*;
#(
    parameter bit RESET_24H = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output cal_time_t         stage,
    output logic              pend,
    output logic              mode24
);
    typedef struct packed {
        cal_time_t stg;
        logic      pend;
        logic      m24;
    } shd_t;

    shd_t shd_d, shd_q;
    logic unused_bits;
    assign unused_bits = ^wdata[REG_W-2:8];

    always_comb begin
        shd_d      = shd_q;
        shd_d.pend = 1'b0;
        if (wr_en) begin
            case (addr)
                ADR_SEC:    shd_d.stg.sec  = wdata[SEC_W-1:0];
                ADR_MIN:    shd_d.stg.min  = wdata[MIN_W-1:0];
                ADR_HOUR:   shd_d.stg.hour = wdata[HR_W-1:0];
                ADR_WDAY:   shd_d.stg.wday = wdata[WD_W-1:0];
                ADR_MDAY:   shd_d.stg.mday = wdata[MD_W-1:0];
                ADR_MON:    shd_d.stg.mon  = wdata[MON_W-1:0];
                ADR_YEAR: begin
                    shd_d.stg.year = wdata[YR_W-1:0];
                    shd_d.stg.leap = wdata[REG_W-1];
                end
                ADR_COMMIT: shd_d.pend     = wdata[REG_W-1];
                ADR_CTRL:   shd_d.m24      = wdata[0];
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shd_q.stg  <= CAL_RESET;
            shd_q.pend <= 1'b0;
            shd_q.m24  <= RESET_24H;
        end else begin
            shd_q <= shd_d;
        end
    end

    assign stage  = shd_q.stg;
    assign pend   = shd_q.pend;
    assign mode24 = shd_q.m24;
endmodule

// File: rtl/cal_clock.sv
module cal_clock
    import cal_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [SEC_W-1:0] ld_sec,
    input  logic [MIN_W-1:0] ld_min,
    input  logic [HR_W-1:0]  ld_hour,
    input  logic             step,
    input  logic             mode24,
    output logic [SEC_W-1:0] sec,
    output logic [MIN_W-1:0] min,
    output logic [HR_W-1:0]  hour,
    output logic             day_carry
);
    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [MIN_W-1:0] min;
        logic [HR_W-1:0]  hour;
    } tod_t;

    tod_t tod_d, tod_q;
    logic [HR_W-1:0] hour_nx;
    logic            hour_cy;

    // hour successor for both counting modes
    always_comb begin
        hour_cy = 1'b0;
        if (mode24) begin
            if (tod_q.hour >= 6'h23) begin
                hour_nx = 6'h00;
                hour_cy = 1'b1;
            end else begin
                hour_nx = HR_W'(bcd_inc8({2'b00, tod_q.hour}));
            end
        end else begin
            if (tod_q.hour[4:0] == 5'h11) begin
                hour_nx = {~tod_q.hour[5], 5'h12};
                hour_cy = tod_q.hour[5];
            end else if (tod_q.hour[4:0] >= 5'h12) begin
                hour_nx = {tod_q.hour[5], 5'h01};
            end else begin
                hour_nx = {tod_q.hour[5], 5'(bcd_inc8({3'b000, tod_q.hour[4:0]}))};
            end
        end
    end

    always_comb begin
        tod_d     = tod_q;
        day_carry = 1'b0;
        if (load) begin
            tod_d = '{sec: ld_sec, min: ld_min, hour: ld_hour};
        end else if (step) begin
            if (tod_q.sec >= 7'h59) begin
                tod_d.sec = 7'h00;
                if (tod_q.min >= 7'h59) begin
                    tod_d.min  = 7'h00;
                    tod_d.hour = hour_nx;
                    day_carry  = hour_cy;
                end else begin
                    tod_d.min = MIN_W'(bcd_inc8({1'b0, tod_q.min}));
                end
            end else begin
                tod_d.sec = SEC_W'(bcd_inc8({1'b0, tod_q.sec}));
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tod_q <= '{sec: CAL_RESET.sec, min: CAL_RESET.min, hour: CAL_RESET.hour};
        else        tod_q <= tod_d;
    end

    assign sec  = tod_q.sec;
    assign min  = tod_q.min;
    assign hour = tod_q.hour;
endmodule

// File: rtl/cal_date.sv
module cal_date
    import cal_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WD_W-1:0]  ld_wday,
    input  logic [MD_W-1:0]  ld_mday,
    input  logic [MON_W-1:0] ld_mon,
    input  logic [YR_W-1:0]  ld_year,
    input  logic             ld_leap,
    input  logic             day_step,
    output logic [WD_W-1:0]  wday,
    output logic [MD_W-1:0]  mday,
    output logic [MON_W-1:0] mon,
    output logic [YR_W-1:0]  year,
    output logic             leap
);
    typedef struct packed {
        logic [WD_W-1:0]  wday;
        logic [MD_W-1:0]  mday;
        logic [MON_W-1:0] mon;
        logic [YR_W-1:0]  year;
        logic             leap;
    } date_t;

    date_t dt_d, dt_q;
    logic [MD_W-1:0] last_day;

    always_comb begin
        case (dt_q.mon)
            5'h02:                      last_day = dt_q.leap ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: last_day = 6'h30;
            default:                    last_day = 6'h31;
        endcase
    end

    always_comb begin
        dt_d = dt_q;
        if (load) begin
            dt_d = '{wday: ld_wday, mday: ld_mday, mon: ld_mon, year: ld_year, leap: ld_leap};
        end else if (day_step) begin
            dt_d.wday = (dt_q.wday >= 3'd6) ? 3'd0 : dt_q.wday + 3'd1;
            if (dt_q.mday >= last_day) begin
                dt_d.mday = 6'h01;
                if (dt_q.mon >= 5'h12) begin
                    dt_d.mon  = 5'h01;
                    dt_d.year = (dt_q.year >= 8'h99) ? 8'h00 : bcd_inc8(dt_q.year);
                end else begin
                    dt_d.mon = MON_W'(bcd_inc8({3'b000, dt_q.mon}));
                end
            end else begin
                dt_d.mday = MD_W'(bcd_inc8({2'b00, dt_q.mday}));
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dt_q <= '{wday: CAL_RESET.wday, mday: CAL_RESET.mday, mon: CAL_RESET.mon,
                              year: CAL_RESET.year, leap: CAL_RESET.leap};
        else        dt_q <= dt_d;
    end

    assign wday = dt_q.wday;
    assign mday = dt_q.mday;
    assign mon  = dt_q.mon;
    assign year = dt_q.year;
    assign leap = dt_q.leap;
endmodule

// File: rtl/cal_bcd_rtc.sv
module cal_bcd_rtc
    import cal_pkg::*;
#(
    parameter bit RESET_24H = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata
);
    cal_time_t stage, live;
    logic      commit_pend, mode24, step, day_carry;

    assign step = tick & ~commit_pend;

    cal_shadow #(.RESET_24H(RESET_24H)) u_shadow (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .stage(stage), .pend(commit_pend), .mode24(mode24)
    );

    cal_clock u_clock (
        .clk(clk), .rst_n(rst_n), .load(commit_pend),
        .ld_sec(stage.sec), .ld_min(stage.min), .ld_hour(stage.hour),
        .step(step), .mode24(mode24),
        .sec(live.sec), .min(live.min), .hour(live.hour), .day_carry(day_carry)
    );

    cal_date u_date (
        .clk(clk), .rst_n(rst_n), .load(commit_pend),
        .ld_wday(stage.wday), .ld_mday(stage.mday), .ld_mon(stage.mon),
        .ld_year(stage.year), .ld_leap(stage.leap), .day_step(day_carry),
        .wday(live.wday), .mday(live.mday), .mon(live.mon),
        .year(live.year), .leap(live.leap)
    );

    always_comb begin
        case (addr)
            ADR_SEC:    rdata = REG_W'(live.sec);
            ADR_MIN:    rdata = REG_W'(live.min);
            ADR_HOUR:   rdata = REG_W'(live.hour);
            ADR_WDAY:   rdata = REG_W'(live.wday);
            ADR_MDAY:   rdata = REG_W'(live.mday);
            ADR_MON:    rdata = REG_W'(live.mon);
            ADR_YEAR:   rdata = {live.leap, 7'd0, live.year};
            ADR_COMMIT: rdata = {commit_pend, 15'd0};
            ADR_CTRL:   rdata = REG_W'(mode24);
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/cal_rtc_chk.sv
module cal_rtc_chk
    import cal_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      tick,
    input logic      trig_wr,
    input logic      pend,
    input logic      mode24,
    input cal_time_t cur,
    input cal_time_t stage
);
    AST_COMMIT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        pend |=> cur == $past(stage)); // R3
    AST_TRIG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        pend && !trig_wr |=> !pend); // R3
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick && !pend |=> cur == $past(cur)); // R2
    AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        tick && !pend && cur.sec == 7'h59 |=> cur.sec == 7'h00); // R4
    AST_HOUR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        tick && !pend && mode24 && cur.sec == 7'h59 && cur.min == 7'h59 && cur.hour == 6'h23
        |=> cur.hour == 6'h00); // R5
    AST_WDAY_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        tick && !pend && mode24 && cur.sec == 7'h59 && cur.min == 7'h59 && cur.hour == 6'h23
        && cur.wday == 3'd6 |=> cur.wday == 3'd0); // R7
    AST_LEAP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !pend |=> cur.leap == $past(cur.leap)); // R10
    AST_COMMIT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        pend && tick |=> cur.sec == $past(stage.sec)); // R11
endmodule

bind cal_bcd_rtc cal_rtc_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .trig_wr(wr_en && addr == 4'd7 && wdata[15]),
    .pend(commit_pend), .mode24(mode24), .cur(live), .stage(stage)
);

// File: tb/sim_cal_bcd_rtc.sv
`timescale 1ns/1ps
module sim_cal_bcd_rtc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = 4'd0;
    logic [15:0] wdata = 16'd0;
    logic [15:0] rdata;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // binary reference model
    int ms, mm, mh, mwd, md, mmo, my;
    bit mlp;

    always #10 clk = ~clk;

    cal_bcd_rtc u0 (.clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
                    .addr(addr), .wdata(wdata), .rdata(rdata));

    function automatic logic [15:0] bcd(input int n);
        return 16'(((n / 10) << 4) | (n % 10));
    endfunction

    function automatic int dim(input int mo, input bit lp);
        if (mo == 2) return lp ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    task automatic model_tick();
        ms++;
        if (ms == 60) begin
            ms = 0; mm++;
            if (mm == 60) begin
                mm = 0; mh++;
                if (mh == 24) begin
                    mh = 0;
                    mwd = (mwd + 1) % 7;
                    md++;
                    if (md > dim(mmo, mlp)) begin
                        md = 1; mmo++;
                        if (mmo == 13) begin
                            mmo = 1;
                            my = (my + 1) % 100;
                        end
                    end
                end
            end
        end
    endtask

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(posedge clk);
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic load_raw(input logic [15:0] s, input logic [15:0] m, input logic [15:0] h,
                            input logic [15:0] w, input logic [15:0] d, input logic [15:0] mo,
                            input logic [15:0] y);
        wr(4'd0, s); wr(4'd1, m); wr(4'd2, h); wr(4'd3, w);
        wr(4'd4, d); wr(4'd5, mo); wr(4'd6, y);
        wr(4'd7, 16'h8000);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_model(input int s, input int m, input int h, input int w,
                             input int d, input int mo, input int y, input bit lp);
        ms = s; mm = m; mh = h; mwd = w; md = d; mmo = mo; my = y; mlp = lp;
        load_raw(bcd(s), bcd(m), bcd(h), 16'(w), bcd(d), bcd(mo), {lp, 7'd0, bcd(y)[7:0]});
    endtask

    task automatic check_all(input string req);
        logic [15:0] v;
        rd(4'd0, v); check(req, v, bcd(ms));
        rd(4'd1, v); check(req, v, bcd(mm));
        rd(4'd2, v); check(req, v, bcd(mh));
        rd(4'd3, v); check(req, v, 16'(mwd));
        rd(4'd4, v); check(req, v, bcd(md));
        rd(4'd5, v); check(req, v, bcd(mmo));
        rd(4'd6, v); check(req, v, {mlp, 7'd0, bcd(my)[7:0]});
    endtask

    task automatic run_ticks(input int n);
        ticks(n);
        repeat (n) model_tick();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 20);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] v;
        void'($urandom(32'd20240607));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        ms = 0; mm = 0; mh = 0; mwd = 0; md = 1; mmo = 1; my = 0; mlp = 0;
        check_all("R1");
        rd(4'd8, v); check("R1 ctrl", v, 16'h0001);
        rd(4'd7, v); check("R1 commit", v, 16'h0000);

        // R2 staged writes invisible
        wr(4'd0, 16'h0045); wr(4'd4, 16'h0017);
        repeat (3) @(negedge clk);
        rd(4'd0, v); check("R2 sec", v, 16'h0000);
        rd(4'd4, v); check("R2 mday", v, 16'h0001);

        // R3 commit with bit 15 clear does nothing
        wr(4'd7, 16'h7FFF);
        rd(4'd7, v); check("R3 no pend", v, 16'h0000);
        @(negedge clk);
        rd(4'd0, v); check("R3 no load", v, 16'h0000);

        // R3 pending readback then load
        wr(4'd7, 16'h8000);
        rd(4'd7, v); check("R3 pend", v, 16'h8000);
        @(negedge clk);
        rd(4'd7, v); check("R3 cleared", v, 16'h0000);
        rd(4'd0, v); check("R3 sec", v, 16'h0045);
        rd(4'd4, v); check("R3 mday", v, 16'h0017);

        // R11 tick on load cycle dropped
        wr(4'd0, 16'h0020);
        wr(4'd7, 16'h8000);
        tick = 1'b1;
        @(posedge clk);
        @(negedge clk);
        tick = 1'b0;
        rd(4'd0, v); check("R11", v, 16'h0020);

        // R12 field width masking
        load_raw(16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF);
        rd(4'd0, v); check("R12 sec", v, 16'h007F);
        rd(4'd2, v); check("R12 hour", v, 16'h003F);
        rd(4'd3, v); check("R12 wday", v, 16'h0007);
        rd(4'd5, v); check("R12 mon", v, 16'h001F);
        rd(4'd6, v); check("R12 year", v, 16'h80FF);

        // R4 BCD digit carry
        set_model(9, 0, 0, 0, 1, 1, 0, 0);
        run_ticks(1); check_all("R4 digit");
        set_model(59, 59, 10, 2, 5, 3, 24, 0);
        run_ticks(1); check_all("R4 minute carry");

        // R5 hours wrap
        set_model(59, 59, 23, 1, 14, 7, 33, 0);
        run_ticks(1); check_all("R5");

        // R7 weekday wrap
        set_model(59, 59, 23, 6, 10, 8, 50, 0);
        run_ticks(1); check_all("R7");

        // R8 month lengths
        set_model(59, 59, 23, 0, 30, 4, 12, 0);
        run_ticks(1); check_all("R8 april");
        set_model(59, 59, 23, 0, 30, 1, 12, 0);
        run_ticks(1); check_all("R8 january");
        set_model(59, 59, 23, 0, 30, 11, 12, 0);
        run_ticks(1); check_all("R8 november");

        // R9 february
        set_model(59, 59, 23, 3, 28, 2, 41, 0);
        run_ticks(1); check_all("R9 common");
        set_model(59, 59, 23, 3, 28, 2, 42, 1);
        run_ticks(1); check_all("R9 leap 29");
        set_model(59, 59, 23, 3, 29, 2, 42, 1);
        run_ticks(1); check_all("R9 leap end");

        // R10 year rollover keeps leap flag
        set_model(59, 59, 23, 4, 31, 12, 99, 1);
        run_ticks(1); check_all("R10 wrap");
        set_model(59, 59, 23, 4, 31, 12, 19, 0);
        run_ticks(1); check_all("R10 inc");

        // R6 12-hour mode
        wr(4'd8, 16'h0000);
        rd(4'd8, v); check("R6 ctrl", v, 16'h0000);
        load_raw(16'h0059, 16'h0059, 16'h0011, 16'h0002, 16'h0005, 16'h0003, 16'h0010);
        ticks(1);
        rd(4'd2, v); check("R6 11AM", v, 16'h0032);
        rd(4'd4, v); check("R6 11AM day", v, 16'h0005);
        load_raw(16'h0059, 16'h0059, 16'h0031, 16'h0002, 16'h0005, 16'h0003, 16'h0010);
        ticks(1);
        rd(4'd2, v); check("R6 11PM", v, 16'h0012);
        rd(4'd3, v); check("R6 11PM wday", v, 16'h0003);
        rd(4'd4, v); check("R6 11PM day", v, 16'h0006);
        load_raw(16'h0059, 16'h0059, 16'h0032, 16'h0002, 16'h0005, 16'h0003, 16'h0010);
        ticks(1);
        rd(4'd2, v); check("R6 12PM", v, 16'h0021);
        wr(4'd8, 16'h0001);

        // random starts near rollovers, R4 R5 R8 R9 R10
        for (int it = 0; it < 60; it++) begin
            int s, m, h, mo, d, y;
            bit lp;
            lp = 1'($urandom_range(0, 1));
            mo = $urandom_range(1, 12);
            y  = $urandom_range(0, 99);
            if ($urandom_range(0, 1) == 1) begin
                s = $urandom_range(0, 59); m = $urandom_range(0, 59);
                h = $urandom_range(0, 23); d = $urandom_range(1, dim(mo, lp));
            end else begin
                s = $urandom_range(40, 59); m = 59; h = 23; d = dim(mo, lp);
            end
            set_model(s, m, h, $urandom_range(0, 6), d, mo, y, lp);
            run_ticks($urandom_range(1, 150));
            check_all("R4 R5 R8 R9 R10 random");
        end

        finish_run();
    end
endmodule